// File: doc/BRIEF.md
# Push-Button Press Event Capture

This block takes four raw mechanical push-button lines and turns each clean press into a sticky event bit that a processor can poll. Every line is first passed through a two-flop synchronizer on the fast filter clock. It then goes through a counter-based debounce filter. The filtered level only moves once the synchronized input has disagreed with it for a whole settle window, which defaults to 1,000,000 cycles, about 10 ms at 100 MHz. When the filtered level moves from 0 to 1, the event bit of that button is set. A return to 0 sets nothing.

The processor runs on a much slower clock. It reads the four event bits as one vector and acknowledges them with a clear request. That request is a level driven from the slow domain. Inside the block it is synchronized into the fast domain, and its rising edge becomes a single fast-cycle pulse that wipes all four bits. If a new press lands on the same cycle as that pulse, the press is kept. The external active-low reset is applied asynchronously and released on the clock through a two-flop reset synchronizer.

Top module: `btn_event_latch`

## Requirements
- R1: While reset is asserted, and after it is released with no press, all event bits (`flags[3:0]`, bit i belongs to `btn_raw[i]`) read 0.
- R2: A raw line that rises and then holds high sets its event bit after exactly DEB_LIMIT+2 rising clock edges. The first of those edges is the first one at which the new value is present. The two extra edges come from the synchronizer.
- R3: An input pulse or bounce train in which no stretch of constant value lasts DEB_LIMIT cycles does not move the filtered level, so it sets no event bit.
- R4: Only a 0-to-1 move of the filtered level sets an event bit. A debounced release leaves the bit as it was.
- R5: A rising edge on `clr_req` clears all four event bits together. The clear takes effect at the third rising clock edge at which `clr_req` is high.
- R6: Holding `clr_req` high clears only once. Presses made while it stays high are latched and stay set.
- R7: When a press would set a bit on the same edge that the clear pulse acts, that bit ends up set. The other bits are cleared.
- R8: The four channels are independent. A press on one line never sets the bit of another line.
- R9: A release also needs DEB_LIMIT stable cycles. After a release, a new press sets the bit again only once the filtered level has returned to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast filter clock (100 MHz in the target system) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| btn_raw | input | 4 | Unsynchronized button lines, high when pressed |
| clr_req | input | 1 | Clear request level from the slow processor domain; its rising edge acts |
| flags | output | 4 | Sticky press event bits, one per button |

## Verification
The bench builds the block with DEB_LIMIT set to 8 in place of the million-cycle default. At that setting every settle window, every bounce train shorter than a window, and the exact edge on which a bit sets all fit into a few dozen cycles. The same setting lets the bench place a clear pulse on precisely the edge where a press completes its window. The four-channel width and the two-stage synchronizers keep their default values, so the latency counted in the checks is the one the real block has.

// File: rtl/btn_pkg.sv
package btn_pkg;
  parameter int unsigned BTN_COUNT  = 4;
  parameter int unsigned SYNC_DEPTH = 2;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction
endpackage

// File: rtl/btn_sync_cell.sv
module btn_sync_cell #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;
  logic [STAGES-1:0][WIDTH-1:0] pipe_d;

  always_comb begin
    pipe_d[0] = d_async;
    for (int s = 1; s < STAGES; s++) pipe_d[s] = pipe_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign q_sync = pipe_q[STAGES-1];
endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int unsigned LIMIT = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_sync,
  output logic lvl_o,
  output logic rise_o
);
  localparam int unsigned CW = btn_pkg::cnt_width(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;
  logic          differ, expire, cnt_en;

  always_comb begin
    differ = in_sync ^ lvl_q;
    expire = differ && (cnt_q == LAST);
    cnt_en = differ || (cnt_q != '0);
    cnt_d  = cnt_q;
    lvl_d  = lvl_q;
    if (!differ) begin
      cnt_d = '0;
    end else if (expire) begin
      cnt_d = '0;
      lvl_d = in_sync;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign lvl_o  = lvl_q;
  assign rise_o = expire & in_sync;

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_lvl_after_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> ($past(cnt_q) == LAST));
  assert_lvl_follows_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> ($past(in_sync) == lvl_q));
endmodule

// File: rtl/btn_clear_bridge.sv
module btn_clear_bridge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_slow,
  output logic clr_pulse
);
  logic req_sync;
  logic req_prev_q;

  btn_sync_cell #(.WIDTH(1), .STAGES(STAGES)) req_sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (req_slow),
    .q_sync  (req_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_prev_q <= 1'b0;
    else        req_prev_q <= req_sync;
  end

  assign clr_pulse = req_sync & ~req_prev_q;

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> !clr_pulse);
endmodule

// File: rtl/btn_event_latch.sv
module btn_event_latch #(
  parameter int unsigned BTN_COUNT = btn_pkg::BTN_COUNT,
  parameter int unsigned DEB_LIMIT = 1000000,
  parameter int unsigned SYNC_DEPTH = btn_pkg::SYNC_DEPTH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BTN_COUNT-1:0] btn_raw,
  input  logic                 clr_req,
  output logic [BTN_COUNT-1:0] flags
);
  logic [1:0]           rst_pipe_q;
  logic                 rst_n_int;
  logic [BTN_COUNT-1:0] btn_sync;
  logic [BTN_COUNT-1:0] deb_lvl;
  logic [BTN_COUNT-1:0] deb_rise;
  logic                 clr_pulse;
  logic [BTN_COUNT-1:0] flag_q, flag_d;
  logic                 flag_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  btn_sync_cell #(.WIDTH(BTN_COUNT), .STAGES(SYNC_DEPTH)) btn_sync_i (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .d_async (btn_raw),
    .q_sync  (btn_sync)
  );

  for (genvar g = 0; g < BTN_COUNT; g++) begin : g_chan
    btn_debounce #(.LIMIT(DEB_LIMIT)) deb_i (
      .clk     (clk),
      .rst_n   (rst_n_int),
      .in_sync (btn_sync[g]),
      .lvl_o   (deb_lvl[g]),
      .rise_o  (deb_rise[g])
    );

    assert_set_only_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n_int)
      $rose(flag_q[g]) |-> $past(deb_rise[g]));
    assert_press_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n_int)
      deb_rise[g] |=> flag_q[g]);
    assert_clear_acts_R5: assert property (@(posedge clk) disable iff (!rst_n_int)
      (clr_pulse && !deb_rise[g]) |=> !flag_q[g]);
  end

  btn_clear_bridge #(.STAGES(SYNC_DEPTH)) clr_bridge_i (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .req_slow  (clr_req),
    .clr_pulse (clr_pulse)
  );

  always_comb begin
    flag_en = clr_pulse | (|deb_rise);
    flag_d  = (clr_pulse ? '0 : flag_q) | deb_rise;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)   flag_q <= '0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flags = flag_q;

  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!clr_pulse && !$isunknown(flag_q)) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
endmodule

// File: tb/btn_event_latch_tb_top.sv
`timescale 1ns/1ps
module btn_event_latch_tb_top;
  localparam int DL = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] btn_raw;
  logic       clr_req;
  logic [3:0] flags;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit cmp_on = 0;

  btn_event_latch #(.BTN_COUNT(4), .DEB_LIMIT(DL), .SYNC_DEPTH(2)) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .btn_raw (btn_raw),
    .clr_req (clr_req),
    .flags   (flags)
  );

  always #2.5 clk = ~clk;

  // behavioural reference: pipelines as shift variables, run-length counters
  bit       m_s1 [4];
  bit       m_s2 [4];
  bit       m_lvl[4];
  int       m_run[4];
  bit [3:0] m_flg = '0;
  bit       m_c1, m_c2, m_c3;
  int       m_rel = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_lvl[i] = 0; m_run[i] = 0;
      end
      m_flg = '0; m_c1 = 0; m_c2 = 0; m_c3 = 0; m_rel = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      bit       clr;
      bit [3:0] rise;
      clr  = m_c2 && !m_c3;
      rise = '0;
      for (int i = 0; i < 4; i++) begin
        if (m_s2[i] != m_lvl[i]) begin
          m_run[i]++;
          if (m_run[i] == DL) begin
            m_lvl[i] = m_s2[i];
            m_run[i] = 0;
            rise[i]  = m_s2[i];
          end
        end else begin
          m_run[i] = 0;
        end
      end
      m_flg = (clr ? 4'b0 : m_flg) | rise;
      for (int i = 0; i < 4; i++) begin
        m_s2[i] = m_s1[i];
        m_s1[i] = btn_raw[i];
      end
      m_c3 = m_c2; m_c2 = m_c1; m_c1 = clr_req;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      checks++;
      if (flags !== m_flg) begin
        errors++;
        $display("FAIL R2 R5 model compare: flags=%b expected=%b at %0t", flags, m_flg, $time);
      end
    end
  end

  task automatic chk(input logic [3:0] exp, input string req);
    checks++;
    if (flags !== exp) begin
      errors++;
      $display("FAIL %s: flags=%b expected=%b at %0t", req, flags, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b1; btn_raw = '0; clr_req = 1'b0;
    #1 rst_n = 1'b0;
    step(3);
    chk(4'b0000, "R1 during reset");
    cmp_on = 1;
    rst_n = 1'b1;
    step(6);
    chk(4'b0000, "R1 after release");

    // R2: exact latency DL+2 edges
    btn_raw[0] = 1'b1;
    step(DL + 1);
    chk(4'b0000, "R2 one edge before set");
    step(1);
    chk(4'b0001, "R2 set on edge DL+2");

    // R4: release keeps the bit
    btn_raw[0] = 1'b0;
    step(DL + 6);
    chk(4'b0001, "R4 release leaves bit");

    // R5: clear on third edge with clr_req high
    clr_req = 1'b1;
    step(2);
    chk(4'b0001, "R5 before clear edge");
    step(1);
    chk(4'b0000, "R5 cleared");

    // R6: held clear, new press stays latched
    btn_raw[1] = 1'b1;
    step(DL + 2);
    chk(4'b0010, "R6 press under held clear");
    step(10);
    chk(4'b0010, "R6 no second clear");
    clr_req = 1'b0;
    btn_raw[1] = 1'b0;
    step(DL + 6);

    // R3: bounce train with every run shorter than DL
    btn_raw[2] = 1'b1; step(3); btn_raw[2] = 1'b0; step(2);
    btn_raw[2] = 1'b1; step(DL - 1); btn_raw[2] = 1'b0; step(1);
    btn_raw[2] = 1'b1; step(4); btn_raw[2] = 1'b0;
    step(DL + 6);
    chk(4'b0010, "R3 bounce sets nothing");

    // R8: independent channels, staggered
    btn_raw[3] = 1'b1;
    step(4);
    btn_raw[2] = 1'b1;
    step(DL - 2);
    chk(4'b1010, "R8 only line 3 set");
    step(4);
    chk(4'b1110, "R8 line 2 set later");

    // R9: short release glitch on line 3 does not re-arm
    clr_req = 1'b1; step(3); clr_req = 1'b0;
    chk(4'b0000, "R5 clear all");
    btn_raw[3] = 1'b0; step(DL - 2); btn_raw[3] = 1'b1;
    step(DL + 6);
    chk(4'b0000, "R9 short release no new event");
    btn_raw[3] = 1'b0; step(DL + 4); btn_raw[3] = 1'b1;
    step(DL + 2);
    chk(4'b1000, "R9 full release then press");

    // R7: press completes on the clear edge
    btn_raw[2] = 1'b0;
    step(DL + 6);
    btn_raw[0] = 1'b1;
    step(DL - 1);
    clr_req = 1'b1;
    step(2);
    chk(4'b1000, "R7 before coincident edge");
    step(1);
    chk(4'b0001, "R7 press beats clear");
    clr_req = 1'b0;
    step(5);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule